// File: doc/BRIEF.md
# Block-Counted DMA Staging Buffer

This block sits between a host and the data phase of a parallel SCSI-style bus. It holds one 128-byte staging buffer and moves bytes between that buffer and the bus in bursts. Each burst starts on a one-cycle service tick and moves at most 64 bytes. In receive direction the bus fills the buffer and the host drains it. In send direction the host fills the buffer and the bus drains it. Transfers are grouped into 128-byte blocks. The host loads a block count, and the block raises end-of-DMA status once that count has run out. It can also raise an interrupt when the host enables it.

The host sets direction, transfer mode and interrupt enable through one control register. A control write with its start bit set marks the buffer as owned by the engine ("not ready" to the host). The engine services ticks only while the buffer is not ready, a block count is loaded, and the transfer mode agrees with the direction bit. When the last byte of a block moves, the buffer returns to the host, both buffer indexes go back to zero and the block count steps down by one. The host then reads or writes the buffer over a byte stream and starts the next block.

All byte movement uses valid/ready streams, and a byte moves only in a cycle where valid and ready are both high. The bus-side streams are active only during a burst. The engine offers ready (receive) or valid (send) for one cycle at a time and ends the burst in the first cycle where the bus side shows no byte. Because of this, `bus_out_valid` can drop without a transfer. The next burst carries on from the same buffer index. The host streams are open only while the buffer belongs to the host and the host index is below 128.

Top module: `blkdma_top`

## Requirements
- R1: After reset, `buf_not_ready`, `blk_loaded`, `dma_done`, `last_sent` and `irq` are 0, `blk_count` is 0, and neither bus-side stream is active.
- R2: One tick moves at most 64 bytes. If bytes are always available, a burst moves min(64, bytes left in the block).
- R3: A tick does nothing unless `buf_not_ready` is 1 and `blk_loaded` is 1.
- R4: Control bits [1:0] select the transfer mode: 1 is receive, 2 is send, 0 and 3 are off. Control bit 2 is the direction bit. Receive needs direction 1 and send needs direction 0. Any other combination makes a tick move no bytes.
- R5: A burst ends at the first cycle with no byte pending on the bus side: `bus_in_valid` low in receive, `bus_out_ready` low in send. The next burst resumes at the same buffer index, so buffer order matches bus order.
- R6: When the 128th byte of a block moves, `buf_not_ready` clears, the engine index and host index reset to 0, and `blk_count` decrements modulo 256. A loaded count of 0 becomes 255.
- R7: When the count steps from 1 to 0, `blk_loaded` clears and `dma_done` sets. `irq` sets only if control bit 3 (interrupt enable) is 1.
- R8: A send-mode block that brings the count to 0 also sets `last_sent`. A receive block never sets it.
- R9: Writing `reg_sel`=0 loads `blk_count` and sets `blk_loaded`. Writing `reg_sel`=1 copies control bit 4 (start) into `buf_not_ready`, resets the host index, and clears `dma_done`, `irq` and `last_sent`.
- R10: `hw_ready` and `hr_valid` are high only while `buf_not_ready` is 0 and the host index is below 128. Each host transfer steps the host index by one, and `hr_data` is the byte at the host index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = block count, 1 = control |
| reg_wdata | input | 8 | Register write data |
| tick | input | 1 | Service tick, starts a burst |
| hw_valid | input | 1 | Host write byte valid |
| hw_ready | output | 1 | Host write byte accepted |
| hw_data | input | 8 | Host write byte |
| hr_valid | output | 1 | Host read byte available |
| hr_ready | input | 1 | Host takes read byte |
| hr_data | output | 8 | Host read byte |
| bus_in_valid | input | 1 | Bus byte pending (receive) |
| bus_in_ready | output | 1 | Engine takes bus byte |
| bus_in_data | input | 8 | Bus byte in |
| bus_out_valid | output | 1 | Engine offers byte (send) |
| bus_out_ready | input | 1 | Bus takes byte |
| bus_out_data | output | 8 | Bus byte out |
| blk_count | output | 8 | Remaining block count |
| blk_loaded | output | 1 | Block count loaded |
| buf_not_ready | output | 1 | Buffer owned by engine |
| dma_done | output | 1 | End-of-DMA status |
| last_sent | output | 1 | Final send block complete |
| irq | output | 1 | Interrupt request (level) |

## Verification
The hardest case to reach is a block boundary that falls inside a burst. It matters most when the 64-byte burst cap and the 128-byte block end land on the same byte, and when a bus stall leaves the buffer index part-way through a block. The stimulus reaches these cases directly with bursts of 64, 10 and 54 bytes, and with a block count of 0 that wraps to 255. Seeded random burst lengths from 0 to 80 then make stalls land at arbitrary buffer indexes, over several blocks of mixed direction. Every buffer byte is compared at the opposite port.

// File: rtl/blkdma_pkg.sv
`timescale 1ns/1ps
package blkdma_pkg;
  typedef enum logic [1:0] {
    XM_OFF  = 2'd0,
    XM_RECV = 2'd1,
    XM_SEND = 2'd2,
    XM_RSVD = 2'd3
  } xfer_mode_e;

  // control byte layout: [4] start, [3] irq enable, [2] direction, [1:0] mode
  typedef struct packed {
    logic       start;
    logic       irq_en;
    logic       dir;
    xfer_mode_e mode;
  } ctrl_t;
endpackage

// File: rtl/blkdma_store.sv
`timescale 1ns/1ps
module blkdma_store #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_a_addr,
  output logic [DW-1:0] rd_a_data,
  input  logic [AW-1:0] rd_b_addr,
  output logic [DW-1:0] rd_b_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_a_data = mem[rd_a_addr];
  assign rd_b_data = mem[rd_b_addr];
endmodule

// File: rtl/blkdma_regs.sv
`timescale 1ns/1ps
module blkdma_regs
  import blkdma_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [DW-1:0] reg_wdata,
  input  logic          blk_done,
  input  logic          blk_send,
  output logic [DW-1:0] blk_count,
  output logic          loaded,
  output logic          not_ready,
  output xfer_mode_e    cfg_mode,
  output logic          cfg_dir,
  output logic          cfg_irq_en,
  output logic          end_dma,
  output logic          irq_pend,
  output logic          last_sent,
  output logic          ctrl_wr_p
);
  logic  cnt_wr;
  logic  last_blk;
  ctrl_t wr_ctrl;

  assign cnt_wr    = reg_wr && !reg_sel;
  assign ctrl_wr_p = reg_wr && reg_sel;
  assign wr_ctrl   = ctrl_t'(reg_wdata[4:0]);
  assign last_blk  = blk_done && (blk_count == DW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_mode   <= XM_OFF;
      cfg_dir    <= 1'b0;
      cfg_irq_en <= 1'b0;
      not_ready  <= 1'b0;
    end else if (ctrl_wr_p) begin
      cfg_mode   <= wr_ctrl.mode;
      cfg_dir    <= wr_ctrl.dir;
      cfg_irq_en <= wr_ctrl.irq_en;
      not_ready  <= wr_ctrl.start;
    end else if (blk_done) begin
      not_ready  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_count <= '0;
      loaded    <= 1'b0;
    end else if (cnt_wr) begin
      blk_count <= reg_wdata;
      loaded    <= 1'b1;
    end else if (blk_done) begin
      blk_count <= blk_count - DW'(1);
      if (last_blk) loaded <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_dma   <= 1'b0;
      irq_pend  <= 1'b0;
      last_sent <= 1'b0;
    end else if (ctrl_wr_p) begin
      end_dma   <= 1'b0;
      irq_pend  <= 1'b0;
      last_sent <= 1'b0;
    end else if (last_blk) begin
      end_dma <= 1'b1;
      if (cfg_irq_en) irq_pend  <= 1'b1;
      if (blk_send)   last_sent <= 1'b1;
    end
  end
endmodule

// File: rtl/blkdma_burst.sv
`timescale 1ns/1ps
module blkdma_burst #(
  parameter int DEPTH = 128,
  parameter int BURST = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int BW   = $clog2(BURST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          svc_ok,
  input  logic          mode_recv,
  input  logic          bus_in_valid,
  output logic          bus_in_ready,
  output logic          bus_out_valid,
  input  logic          bus_out_ready,
  output logic [AW-1:0] buf_idx,
  output logic          mem_we,
  output logic          blk_done,
  output logic          burst_send
);
  logic          busy;
  logic          recv_q;
  logic [BW-1:0] bcnt;
  logic          have;
  logic          fire;
  logic          cap_hit;

  assign have     = recv_q ? bus_in_valid : bus_out_ready;
  assign fire     = busy && have;
  assign blk_done = fire && (buf_idx == AW'(DEPTH - 1));
  assign cap_hit  = fire && (bcnt == BW'(BURST - 1));
  assign mem_we   = fire && recv_q;

  assign bus_in_ready  = busy && recv_q;
  assign bus_out_valid = busy && !recv_q;
  assign burst_send    = !recv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      recv_q  <= 1'b0;
      bcnt    <= '0;
      buf_idx <= '0;
    end else if (!busy) begin
      if (tick && svc_ok) begin
        busy   <= 1'b1;
        recv_q <= mode_recv;
        bcnt   <= '0;
      end
    end else begin
      if (!have || blk_done || cap_hit) busy <= 1'b0;
      if (fire) begin
        bcnt    <= bcnt + BW'(1);
        buf_idx <= blk_done ? '0 : buf_idx + AW'(1);
      end
    end
  end
endmodule

// File: rtl/blkdma_top.sv
`timescale 1ns/1ps
module blkdma_top
  import blkdma_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int BURST = 64,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [DW-1:0] reg_wdata,
  input  logic          tick,
  input  logic          hw_valid,
  output logic          hw_ready,
  input  logic [DW-1:0] hw_data,
  output logic          hr_valid,
  input  logic          hr_ready,
  output logic [DW-1:0] hr_data,
  input  logic          bus_in_valid,
  output logic          bus_in_ready,
  input  logic [DW-1:0] bus_in_data,
  output logic          bus_out_valid,
  input  logic          bus_out_ready,
  output logic [DW-1:0] bus_out_data,
  output logic [DW-1:0] blk_count,
  output logic          blk_loaded,
  output logic          buf_not_ready,
  output logic          dma_done,
  output logic          last_sent,
  output logic          irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int HW = AW + 1;

  xfer_mode_e    cfg_mode;
  logic          cfg_dir;
  logic          cfg_irq_en;
  logic          ctrl_wr_p;
  logic          svc_ok;
  logic          blk_done;
  logic          burst_send;
  logic          mem_we;
  logic [AW-1:0] buf_idx;
  logic [HW-1:0] hidx;
  logic          host_open;
  logic          hw_fire;
  logic          hr_fire;
  logic          st_we;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_data;

  blkdma_regs #(.DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .blk_done   (blk_done),
    .blk_send   (burst_send),
    .blk_count  (blk_count),
    .loaded     (blk_loaded),
    .not_ready  (buf_not_ready),
    .cfg_mode   (cfg_mode),
    .cfg_dir    (cfg_dir),
    .cfg_irq_en (cfg_irq_en),
    .end_dma    (dma_done),
    .irq_pend   (irq),
    .last_sent  (last_sent),
    .ctrl_wr_p  (ctrl_wr_p)
  );

  assign svc_ok = buf_not_ready && blk_loaded &&
                  (((cfg_mode == XM_RECV) && cfg_dir) ||
                   ((cfg_mode == XM_SEND) && !cfg_dir));

  blkdma_burst #(.DEPTH(DEPTH), .BURST(BURST)) u_burst (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .svc_ok        (svc_ok),
    .mode_recv     (cfg_mode == XM_RECV),
    .bus_in_valid  (bus_in_valid),
    .bus_in_ready  (bus_in_ready),
    .bus_out_valid (bus_out_valid),
    .bus_out_ready (bus_out_ready),
    .buf_idx       (buf_idx),
    .mem_we        (mem_we),
    .blk_done      (blk_done),
    .burst_send    (burst_send)
  );

  // host-side index: shared by the read and write streams
  assign host_open = !buf_not_ready && (hidx < HW'(DEPTH));
  assign hw_ready  = host_open;
  assign hr_valid  = host_open;
  assign hw_fire   = hw_valid && host_open;
  assign hr_fire   = hr_ready && host_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      hidx <= '0;
    else if (blk_done || ctrl_wr_p)  hidx <= '0;
    else if (hw_fire || hr_fire)     hidx <= hidx + HW'(1);
  end

  assign st_we   = mem_we || hw_fire;
  assign st_addr = mem_we ? buf_idx : hidx[AW-1:0];
  assign st_data = mem_we ? bus_in_data : hw_data;

  blkdma_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk       (clk),
    .wr_en     (st_we),
    .wr_addr   (st_addr),
    .wr_data   (st_data),
    .rd_a_addr (hidx[AW-1:0]),
    .rd_a_data (hr_data),
    .rd_b_addr (buf_idx),
    .rd_b_data (bus_out_data)
  );
endmodule

// File: rtl/blkdma_chk.sv
`timescale 1ns/1ps
module blkdma_chk #(
  parameter int BURST = 64,
  parameter int DW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          cfg_dir,
  input logic          buf_not_ready,
  input logic          blk_loaded,
  input logic [DW-1:0] blk_count,
  input logic          dma_done,
  input logic          irq,
  input logic          last_sent,
  input logic          bus_in_valid,
  input logic          bus_in_ready,
  input logic          bus_out_valid,
  input logic          bus_out_ready
);
  logic       active;
  logic       xfer;
  logic [7:0] run_bytes;

  assign active = bus_in_ready || bus_out_valid;
  assign xfer   = (bus_in_ready && bus_in_valid) || (bus_out_valid && bus_out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_bytes <= '0;
    else if (!active) run_bytes <= '0;
    else if (xfer)    run_bytes <= run_bytes + 8'd1;
  end

  AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (run_bytes < 8'(BURST))); // R2
  AST_SVC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (buf_not_ready && blk_loaded)); // R3
  AST_RECV_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_in_ready) |-> cfg_dir); // R4
  AST_SEND_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_out_valid) |-> !cfg_dir); // R4
  AST_STALL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_in_ready && !bus_in_valid) |=> !bus_in_ready); // R5
  AST_BLK_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(buf_not_ready) && !$past(reg_wr)) |-> (blk_count == $past(blk_count) - DW'(1))); // R6
  AST_END_UNLOADS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_done) |-> !blk_loaded); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> dma_done); // R7
  AST_LAST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(last_sent) |-> dma_done); // R8
endmodule

bind blkdma_top blkdma_chk #(.BURST(BURST), .DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr        (reg_wr),
  .cfg_dir       (cfg_dir),
  .buf_not_ready (buf_not_ready),
  .blk_loaded    (blk_loaded),
  .blk_count     (blk_count),
  .dma_done      (dma_done),
  .irq           (irq),
  .last_sent     (last_sent),
  .bus_in_valid  (bus_in_valid),
  .bus_in_ready  (bus_in_ready),
  .bus_out_valid (bus_out_valid),
  .bus_out_ready (bus_out_ready)
);

// File: tb/tb_blkdma_top.sv
`timescale 1ns/1ps
module tb_blkdma_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       tick = 1'b0;
  logic       hw_valid = 1'b0;
  logic       hw_ready;
  logic [7:0] hw_data = '0;
  logic       hr_valid;
  logic       hr_ready = 1'b0;
  logic [7:0] hr_data;
  logic       bus_in_valid = 1'b0;
  logic       bus_in_ready;
  logic [7:0] bus_in_data = '0;
  logic       bus_out_valid;
  logic       bus_out_ready = 1'b0;
  logic [7:0] bus_out_data;
  logic [7:0] blk_count;
  logic       blk_loaded, buf_not_ready, dma_done, last_sent, irq;

  always #2 clk = ~clk;

  blkdma_top dut (.*);

  int nchk = 0;
  int nfail = 0;
  int midx = 0;
  int send_err = 0;
  bit finished = 1'b0;
  logic [7:0] exp_buf [128];

  localparam logic [1:0] M_RECV = 2'd1;
  localparam logic [1:0] M_SEND = 2'd2;

  task automatic chk_eq(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int min3(input int a, input int b, input int c);
    int m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

  task automatic reg_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  task automatic ctrl(input logic [1:0] mode, input logic dir, input logic ien, input logic start);
    reg_write(1'b1, {3'b000, start, ien, dir, mode});
  endtask

  task automatic recv_burst(input int avail, output int moved);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    moved = 0;
    for (int k = 0; k < 300; k++) begin
      bus_in_valid = (k < avail);
      bus_in_data  = 8'($urandom);
      #1;
      if (!bus_in_ready) break;
      if (bus_in_valid) begin
        exp_buf[midx] = bus_in_data;
        midx = (midx + 1) % 128;
        moved++;
      end
      @(negedge clk);
    end
    bus_in_valid = 1'b0;
  endtask

  task automatic send_burst(input int avail, output int moved);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    moved = 0;
    for (int k = 0; k < 300; k++) begin
      bus_out_ready = (k < avail);
      #1;
      if (!bus_out_valid) break;
      if (bus_out_ready) begin
        if (bus_out_data != exp_buf[midx]) send_err++;
        midx = (midx + 1) % 128;
        moved++;
      end
      @(negedge clk);
    end
    bus_out_ready = 1'b0;
  endtask

  task automatic recv_block();
    int rem, av, mv;
    rem = 128 - midx;
    while (rem > 0) begin
      av = $urandom_range(0, 80);
      recv_burst(av, mv);
      chk_eq("R2 recv burst size", mv, min3(av, 64, rem));
      rem -= mv;
    end
  endtask

  task automatic send_block();
    int rem, av, mv;
    send_err = 0;
    rem = 128 - midx;
    while (rem > 0) begin
      av = $urandom_range(0, 80);
      send_burst(av, mv);
      chk_eq("R2 send burst size", mv, min3(av, 64, rem));
      rem -= mv;
    end
    chk_eq("R5 send order", send_err, 0);
  endtask

  task automatic host_read_all();
    int err;
    err = 0;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk); hr_ready = 1'b1; #1;
      if (!hr_valid || hr_data != exp_buf[i]) err++;
    end
    @(negedge clk); hr_ready = 1'b0; #1;
    chk_eq("R5 R10 host read data", err, 0);
    chk_eq("R10 read closed at 128", int'(hr_valid), 0);
  endtask

  task automatic host_write_all();
    int err;
    err = 0;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk); hw_valid = 1'b1; hw_data = 8'($urandom); exp_buf[i] = hw_data; #1;
      if (!hw_ready) err++;
    end
    @(negedge clk); hw_valid = 1'b0; #1;
    chk_eq("R10 host write accepted", err, 0);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int mv;
    int unsigned seed;
    bit snd;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk_eq("R1 not_ready", int'(buf_not_ready), 0);
    chk_eq("R1 loaded", int'(blk_loaded), 0);
    chk_eq("R1 count", int'(blk_count), 0);
    chk_eq("R1 flags", int'({dma_done, last_sent, irq}), 0);
    chk_eq("R1 bus idle", int'({bus_in_ready, bus_out_valid}), 0);
    rst_n = 1'b1;

    // R3: no count loaded
    ctrl(M_RECV, 1'b1, 1'b1, 1'b1);
    chk_eq("R9 start sets not_ready", int'(buf_not_ready), 1);
    chk_eq("R10 host write closed", int'(hw_ready), 0);
    recv_burst(50, mv);
    chk_eq("R3 unloaded tick", mv, 0);

    // R4: direction mismatch both ways
    reg_write(1'b0, 8'd2);
    chk_eq("R9 count load", int'(blk_loaded), 1);
    chk_eq("R9 count value", int'(blk_count), 2);
    ctrl(M_RECV, 1'b0, 1'b1, 1'b1);
    recv_burst(50, mv);
    chk_eq("R4 recv with dir 0", mv, 0);
    ctrl(M_SEND, 1'b1, 1'b1, 1'b1);
    send_burst(50, mv);
    chk_eq("R4 send with dir 1", mv, 0);

    // directed: cap, early stop, resume, block end
    ctrl(M_RECV, 1'b1, 1'b1, 1'b1);
    recv_burst(100, mv);
    chk_eq("R2 burst cap", mv, 64);
    recv_burst(10, mv);
    chk_eq("R5 early stop", mv, 10);
    chk_eq("R5 engine still owns", int'(buf_not_ready), 1);
    recv_burst(100, mv);
    chk_eq("R6 block tail", mv, 54);
    chk_eq("R6 not_ready cleared", int'(buf_not_ready), 0);
    chk_eq("R6 count decremented", int'(blk_count), 1);
    chk_eq("R6 not yet done", int'(dma_done), 0);
    host_read_all();

    // last block, receive, irq enabled
    ctrl(M_RECV, 1'b1, 1'b1, 1'b1);
    recv_block();
    chk_eq("R7 count zero", int'(blk_count), 0);
    chk_eq("R7 unloaded", int'(blk_loaded), 0);
    chk_eq("R7 done", int'(dma_done), 1);
    chk_eq("R7 irq enabled", int'(irq), 1);
    chk_eq("R8 recv no last_sent", int'(last_sent), 0);
    host_read_all();
    ctrl(M_RECV, 1'b1, 1'b1, 1'b1);
    chk_eq("R9 ctrl clears flags", int'({dma_done, irq, last_sent}), 0);
    recv_burst(50, mv);
    chk_eq("R3 tick after end", mv, 0);

    // send block, irq disabled
    reg_write(1'b0, 8'd1);
    ctrl(M_SEND, 1'b0, 1'b0, 1'b0);
    chk_eq("R9 start 0 releases buffer", int'(buf_not_ready), 0);
    host_write_all();
    chk_eq("R10 write closed at 128", int'(hw_ready), 0);
    ctrl(M_SEND, 1'b0, 1'b0, 1'b1);
    send_block();
    chk_eq("R7 send done", int'(dma_done), 1);
    chk_eq("R7 irq masked", int'(irq), 0);
    chk_eq("R8 last_sent", int'(last_sent), 1);
    chk_eq("R7 send unloaded", int'(blk_loaded), 0);

    // count 0 wraps to 255
    reg_write(1'b0, 8'd0);
    ctrl(M_RECV, 1'b1, 1'b0, 1'b1);
    recv_burst(64, mv);
    chk_eq("R2 wrap burst a", mv, 64);
    recv_burst(64, mv);
    chk_eq("R2 wrap burst b", mv, 64);
    chk_eq("R6 wrap count", int'(blk_count), 255);
    chk_eq("R6 wrap still loaded", int'(blk_loaded), 1);
    chk_eq("R6 wrap not done", int'(dma_done), 0);
    host_read_all();

    // random mixed blocks
    reg_write(1'b0, 8'd3);
    for (int b = 0; b < 3; b++) begin
      snd = 1'($urandom_range(0, 1));
      if (snd) begin
        ctrl(M_SEND, 1'b0, 1'b1, 1'b0);
        host_write_all();
        ctrl(M_SEND, 1'b0, 1'b1, 1'b1);
        send_block();
      end else begin
        ctrl(M_RECV, 1'b1, 1'b1, 1'b1);
        recv_block();
        host_read_all();
      end
      chk_eq("R6 random count", int'(blk_count), 2 - b);
    end
    chk_eq("R7 random done", int'(dma_done), 1);
    chk_eq("R7 random irq", int'(irq), 1);
    chk_eq("R8 random last_sent", int'(last_sent), int'(snd));

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule